// File: doc/BRIEF.md
# 22 kHz Signalling Tone Generator and Detector Conditioner

This block derives the 22 kHz signalling carrier for a satellite-receiver supply output from the system clock. It gates that carrier onto the output in one of two ways. When the continuous-tone control is set, the tone runs without a break. When that control is clear, a serial data pin switches the tone on and off, so that data is carried by the presence or absence of bursts. Every gating change waits for the start of a carrier period, so the line never carries a shortened half-cycle. Disable and over-temperature inputs cut the tone at once.

The block also drives the loop-through switch that lets an upstream receiver power the line while this one is in standby. It takes the square pulse train from an analog tone comparator and measures each period against the expected one. From that it produces an active-low "tone detected" output with hysteresis.

Top module: `tone22k_ctrl`

## Requirements
- R1: The carrier half-period is HALF = (CLK_HZ + TONE_HZ) / (2*TONE_HZ) clock cycles, and every high phase of `tone_o` lasts exactly HALF cycles (50% duty).
- R2: With `en_i`=1, `ot_i`=0 and `ten_i`=1, `tone_o` toggles continuously whatever `dsq_i` does: exactly 10 rising edges in any 20*HALF cycles.
- R3: With `ten_i`=0, the tone is sent while the two-flop-synchronised `dsq_i` is 1 and is absent while it is 0.
- R4: Gating changes take effect only where a carrier period begins (a rising edge of the carrier). Every low phase of `tone_o` between two bursts lasts HALF + k*2*HALF cycles, with k >= 0.
- R5: `en_i`=0 forces `tone_o` low in the same cycle, and `lt_close_o`=1 (switch closed) from the next clock edge.
- R6: `en_i`=1 with `ot_i`=0 gives `lt_close_o`=0 (switch open) from the next clock edge. After the enable returns, the tone resumes only at a period start.
- R7: `ot_i`=1 forces `tone_o` low in the same cycle and `lt_close_o`=0 from the next clock edge, whatever `en_i` is.
- R8: Let P = 2*HALF. An interval between synchronised rising edges of `det_i` is good when it is inside [4P/5, 6P/5] cycles. `tone_det_no` goes low after 4 consecutive good intervals. The first edge after reset or after silence does not start a good interval.
- R9: If no rising edge of `det_i` arrives for 2P cycles, `tone_det_no` returns high.
- R10: Two consecutive out-of-window intervals return `tone_det_no` high. A single out-of-window interval followed by a good one leaves it low.
- R11: While `rst_ni` is low: `tone_o`=0, `tone_det_no`=1 and `lt_close_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable power path and tone; 0 = standby |
| ten_i | input | 1 | Continuous tone select |
| dsq_i | input | 1 | Asynchronous data pin gating the carrier |
| ot_i | input | 1 | Over-temperature shutdown |
| det_i | input | 1 | Raw tone comparator pulse train (asynchronous) |
| tone_o | output | 1 | Gated 22 kHz carrier |
| tone_det_no | output | 1 | Tone detected, active low |
| lt_close_o | output | 1 | Loop-through switch closed when 1 |

## Verification
The assertions assume that `en_i` and `ot_i` hold steady for a cycle around each carrier fall they judge, and that the detector input changes no faster than the synchroniser can follow. The stimulus drives every input on the falling clock edge. It holds the enable and temperature inputs constant during each randomised gating run. It spaces detector pulses at least 60 cycles apart and below the silence limit unless silence is the point of the test. The run-length checks on the high phase include only falls that the enable or temperature inputs did not cause.

// File: rtl/tone22k_pkg.sv
package tone22k_pkg;
  function automatic int unsigned half_div(input int unsigned clk_hz, input int unsigned tone_hz);
    return (clk_hz + tone_hz) / (2 * tone_hz);
  endfunction
endpackage

// File: rtl/tone_div.sv
module tone_div #(
  parameter int unsigned HALF = 45,
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic car_o,
  output logic bnd_o
);
  logic [CW-1:0] cnt_q;
  logic          car_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      car_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      car_q <= ~car_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign car_o = car_q;
  // carrier rises on the next edge: period start
  assign bnd_o = wrap & ~car_q;
endmodule

// File: rtl/tone_gate.sv
module tone_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ten_i,
  input  logic dsq_i,
  input  logic ot_i,
  input  logic car_i,
  input  logic bnd_i,
  output logic tone_o
);
  logic [1:0] dsq_s;
  logic       gate_q;
  logic       run_ok;

  assign run_ok = en_i & ~ot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dsq_s <= '0;
    else         dsq_s <= {dsq_s[0], dsq_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gate_q <= 1'b0;
    else if (!run_ok) gate_q <= 1'b0;
    else if (bnd_i)   gate_q <= ten_i | dsq_s[1];
  end

  assign tone_o = car_i & gate_q & run_ok;
endmodule

// File: rtl/tone_det.sv
module tone_det #(
  parameter int unsigned PERIOD = 90,
  parameter int unsigned GOOD_N = 4,
  parameter int unsigned BAD_N  = 2,
  localparam int unsigned LO    = (4 * PERIOD) / 5,
  localparam int unsigned HI    = (6 * PERIOD) / 5,
  localparam int unsigned MISS  = 2 * PERIOD,
  localparam int unsigned TW    = $clog2(MISS + 1),
  localparam int unsigned GW    = $clog2(GOOD_N + 1),
  localparam int unsigned BW    = $clog2(BAD_N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          det_i,
  output logic          det_o,
  output logic [TW-1:0] tmr_o,
  output logic          edge_o
);
  logic [2:0]    sy_q;
  logic [TW-1:0] tmr_q;
  logic [GW-1:0] good_q;
  logic [BW-1:0] bad_q;
  logic          det_q;
  logic          rise;
  logic          in_win;

  assign rise   = sy_q[1] & ~sy_q[2];
  assign in_win = (tmr_q >= TW'(LO)) && (tmr_q <= TW'(HI));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sy_q <= '0;
    else         sy_q <= {sy_q[1:0], det_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= TW'(MISS);
      good_q <= '0;
      bad_q  <= '0;
      det_q  <= 1'b0;
    end else if (rise) begin
      tmr_q <= TW'(1);
      if (in_win) begin
        bad_q <= '0;
        if (good_q != GW'(GOOD_N))     good_q <= good_q + 1'b1;
        if (good_q == GW'(GOOD_N - 1)) det_q  <= 1'b1;
      end else begin
        good_q <= '0;
        if (bad_q != BW'(BAD_N))       bad_q <= bad_q + 1'b1;
        if (bad_q == BW'(BAD_N - 1))   det_q <= 1'b0;
      end
    end else if (tmr_q != TW'(MISS)) begin
      tmr_q <= tmr_q + 1'b1;
    end else begin
      // silence for two periods
      det_q  <= 1'b0;
      good_q <= '0;
      bad_q  <= '0;
    end
  end

  assign det_o  = det_q;
  assign tmr_o  = tmr_q;
  assign edge_o = rise;
endmodule

// File: rtl/tone22k_ctrl.sv
module tone22k_ctrl #(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned TONE_HZ = 22_000,
  localparam int unsigned HALF   = tone22k_pkg::half_div(CLK_HZ, TONE_HZ),
  localparam int unsigned PERIOD = 2 * HALF,
  localparam int unsigned MISS   = 2 * PERIOD,
  localparam int unsigned TW     = $clog2(MISS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ten_i,
  input  logic dsq_i,
  input  logic ot_i,
  input  logic det_i,
  output logic tone_o,
  output logic tone_det_no,
  output logic lt_close_o
);
  logic          car;
  logic          bnd;
  logic          det;
  logic [TW-1:0] det_tmr;
  logic          det_edge;
  logic          lt_q;

  tone_div #(.HALF(HALF)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .car_o (car),
    .bnd_o (bnd)
  );

  tone_gate u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .ten_i (ten_i),
    .dsq_i (dsq_i),
    .ot_i  (ot_i),
    .car_i (car),
    .bnd_i (bnd),
    .tone_o(tone_o)
  );

  tone_det #(.PERIOD(PERIOD)) u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .det_i (det_i),
    .det_o (det),
    .tmr_o (det_tmr),
    .edge_o(det_edge)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lt_q <= 1'b1;
    else         lt_q <= ~en_i & ~ot_i;
  end

  assign lt_close_o  = lt_q;
  assign tone_det_no = ~det;
endmodule

// File: rtl/tone22k_ctrl_chk.sv
module tone22k_ctrl_chk #(
  parameter int unsigned HALF = 45,
  parameter int unsigned MISS = 180,
  parameter int unsigned TW   = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          ot_i,
  input logic          tone_o,
  input logic          tone_det_no,
  input logic          lt_close_o,
  input logic [TW-1:0] tmr_i,
  input logic          edge_i
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (tone_o) run_q <= run_q + 1;
    else             run_q <= '0;
  end

  // R1
  high_phase_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tone_o && $past(tone_o) && en_i && !ot_i && $past(en_i) && !$past(ot_i)) |-> (run_q == HALF));

  // R5
  standby_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !ot_i) |=> lt_close_o);

  // R6
  active_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ot_i) |=> !lt_close_o);

  // R7
  hot_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_i |=> !lt_close_o);

  // R9
  silence_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_i == TW'(MISS) && !edge_i) |=> tone_det_no);
endmodule

bind tone22k_ctrl tone22k_ctrl_chk #(.HALF(HALF), .MISS(MISS), .TW(TW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .ot_i       (ot_i),
  .tone_o     (tone_o),
  .tone_det_no(tone_det_no),
  .lt_close_o (lt_close_o),
  .tmr_i      (det_tmr),
  .edge_i     (det_edge)
);

// File: tb/tb_tone22k_ctrl.sv
`timescale 1ns/1ps
module tb_tone22k_ctrl;
  localparam int unsigned CLK_HZ  = 2_000_000;
  localparam int unsigned TONE_HZ = 22_000;
  localparam int HALF = (CLK_HZ + TONE_HZ) / (2 * TONE_HZ);
  localparam int P    = 2 * HALF;
  localparam int LO   = (4 * P) / 5;
  localparam int HI   = (6 * P) / 5;
  localparam int MISS = 2 * P;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, ten_i = 1'b0, dsq_i = 1'b0, ot_i = 1'b0, det_i = 1'b0;
  logic tone_o, tone_det_no, lt_close_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  tone22k_ctrl #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .ten_i(ten_i), .dsq_i(dsq_i),
    .ot_i(ot_i), .det_i(det_i), .tone_o(tone_o), .tone_det_no(tone_det_no),
    .lt_close_o(lt_close_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run-length monitor for tone phases
  bit mon_on = 1'b0;
  bit seen = 1'b0;
  logic prev_t = 1'b0;
  int run = 0;
  always @(negedge clk_i) begin
    if (mon_on) begin
      if (tone_o !== prev_t) begin
        if (seen) begin
          if (prev_t) chk(run == HALF, "R1 high phase", run, HALF);
          else        chk(run % P == HALF, "R4 low phase mod period", run % P, HALF);
        end
        seen = 1'b1;
        run = 1;
        prev_t = tone_o;
      end else run++;
    end else begin
      seen = 1'b0;
      run = 0;
      prev_t = tone_o;
    end
  end

  task automatic count_rises(input int n, output int c);
    logic pv;
    c = 0;
    pv = tone_o;
    repeat (n) begin
      @(negedge clk_i);
      if (tone_o && !pv) c++;
      pv = tone_o;
    end
  endtask

  task automatic wait_tone_high();
    do @(negedge clk_i); while (!tone_o);
  endtask

  // detector reference model
  int  m_good = 0, m_bad = 0, prev_iv = 0;
  bit  m_det = 1'b0, m_idle = 1'b1;

  function automatic bit good_iv(input int iv);
    return (iv >= LO) && (iv <= HI);
  endfunction

  task automatic det_pulse(input int iv, input string req);
    det_i = 1'b1;
    if (m_idle || !good_iv(prev_iv)) begin
      m_good = 0;
      if (m_bad < 2) m_bad++;
      if (m_bad == 2) m_det = 1'b0;
    end else begin
      m_bad = 0;
      if (m_good < 4) m_good++;
      if (m_good == 4) m_det = 1'b1;
    end
    m_idle = 1'b0;
    prev_iv = iv;
    repeat (iv / 2) @(negedge clk_i);
    det_i = 1'b0;
    repeat (iv - iv / 2) @(negedge clk_i);
    chk(tone_det_no == !m_det, req, tone_det_no, !m_det);
  endtask

  task automatic det_idle();
    repeat (MISS + 20) @(negedge clk_i);
    m_good = 0; m_bad = 0; m_det = 1'b0; m_idle = 1'b1;
    chk(tone_det_no == 1'b1, "R9 idle released", tone_det_no, 1);
  endtask

  initial begin
    int c;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk_i);
    // R11
    chk(tone_o == 1'b0, "R11 tone in reset", tone_o, 0);
    chk(tone_det_no == 1'b1, "R11 detect in reset", tone_det_no, 1);
    chk(lt_close_o == 1'b1, "R11 switch in reset", lt_close_o, 1);
    rst_ni = 1'b1;

    // R5 standby
    repeat (3) @(negedge clk_i);
    count_rises(4 * P, c);
    chk(c == 0, "R5 no tone in standby", c, 0);
    chk(lt_close_o == 1'b1, "R5 switch closed", lt_close_o, 1);

    // R6 / R2
    en_i = 1'b1; ten_i = 1'b1; dsq_i = 1'b0;
    @(negedge clk_i);
    chk(lt_close_o == 1'b0, "R6 switch open", lt_close_o, 0);
    repeat (2 * P) @(negedge clk_i);
    count_rises(10 * P, c);
    chk(c == 10, "R2 continuous with data low", c, 10);
    wait_tone_high();
    c = 0;
    while (tone_o) begin c++; @(negedge clk_i); end
    chk(c == HALF, "R1 measured high phase", c, HALF);

    // R3
    ten_i = 1'b0;
    repeat (2 * P) @(negedge clk_i);
    count_rises(6 * P, c);
    chk(c == 0, "R3 data low suppresses tone", c, 0);
    dsq_i = 1'b1;
    repeat (2 * P) @(negedge clk_i);
    count_rises(10 * P, c);
    chk(c == 10, "R3 data high sends tone", c, 10);

    // R4 random gating, with monitor
    mon_on = 1'b1;
    for (int i = 0; i < 40; i++) begin
      dsq_i = 1'($urandom_range(0, 1));
      ten_i = ($urandom_range(0, 7) == 0);
      repeat ($urandom_range(5, 400)) @(negedge clk_i);
    end
    // R4 directed: toggle near a boundary
    ten_i = 1'b0; dsq_i = 1'b1;
    wait_tone_high();
    dsq_i = 1'b0;
    repeat (HALF - 1) @(negedge clk_i);
    dsq_i = 1'b1;
    repeat (6 * P) @(negedge clk_i);
    mon_on = 1'b0;

    // R5 immediate cut and R6 resume
    dsq_i = 1'b1;
    wait_tone_high();
    en_i = 1'b0;
    #1;
    chk(tone_o == 1'b0, "R5 tone cut same cycle", tone_o, 0);
    @(negedge clk_i);
    chk(lt_close_o == 1'b1, "R5 switch closes next edge", lt_close_o, 1);
    repeat (7) @(negedge clk_i);
    mon_on = 1'b1;
    en_i = 1'b1;
    @(negedge clk_i);
    chk(lt_close_o == 1'b0, "R6 switch reopens", lt_close_o, 0);
    repeat (6 * P) @(negedge clk_i);
    mon_on = 1'b0;

    // R7 over-temperature
    wait_tone_high();
    ot_i = 1'b1;
    #1;
    chk(tone_o == 1'b0, "R7 tone cut same cycle", tone_o, 0);
    @(negedge clk_i);
    chk(lt_close_o == 1'b0, "R7 switch open", lt_close_o, 0);
    en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(lt_close_o == 1'b0, "R7 switch open in standby", lt_close_o, 0);
    count_rises(3 * P, c);
    chk(c == 0, "R7 no tone while hot", c, 0);
    ot_i = 1'b0; en_i = 1'b1;

    // R8 detection threshold
    for (int i = 0; i < 4; i++) det_pulse(P, "R8 before fourth interval");
    chk(tone_det_no == 1'b1, "R8 three intervals not enough", tone_det_no, 1);
    det_pulse(P, "R8 fourth interval");
    chk(tone_det_no == 1'b0, "R8 detected", tone_det_no, 0);
    det_pulse(HI, "R8 upper edge");
    det_pulse(P, "R8 upper edge kept");
    chk(tone_det_no == 1'b0, "R8 upper bound accepted", tone_det_no, 0);
    // R9 silence
    repeat (MISS - 10 - P) @(negedge clk_i);
    chk(tone_det_no == 1'b0, "R9 still low before limit", tone_det_no, 0);
    repeat (20) @(negedge clk_i);
    chk(tone_det_no == 1'b1, "R9 released after silence", tone_det_no, 1);
    m_good = 0; m_bad = 0; m_det = 1'b0; m_idle = 1'b1;

    // R8 lower bound, R10 hysteresis
    for (int i = 0; i < 5; i++) det_pulse(LO, "R8 lower edge");
    chk(tone_det_no == 1'b0, "R8 lower bound accepted", tone_det_no, 0);
    det_pulse(130, "R10 sequence");
    det_pulse(P, "R10 single bad interval");
    chk(tone_det_no == 1'b0, "R10 one bad keeps detect", tone_det_no, 0);
    det_pulse(130, "R10 sequence");
    det_pulse(130, "R10 sequence");
    det_pulse(P, "R10 two bad intervals");
    chk(tone_det_no == 1'b1, "R10 two bad release", tone_det_no, 1);
    det_idle();

    // R8 out of window never detects
    for (int i = 0; i < 6; i++) det_pulse(HI + 1, "R8 above window");
    chk(tone_det_no == 1'b1, "R8 above window ignored", tone_det_no, 1);
    det_idle();
    for (int i = 0; i < 6; i++) det_pulse(LO - 1, "R8 below window");
    chk(tone_det_no == 1'b1, "R8 below window ignored", tone_det_no, 1);
    det_idle();

    // random detector traffic vs model (R8 R10)
    for (int i = 0; i < 200; i++) begin
      int iv;
      if ($urandom_range(0, 9) < 8) iv = $urandom_range(LO, HI);
      else if ($urandom_range(0, 1) == 0) iv = $urandom_range(60, LO - 1);
      else iv = $urandom_range(HI + 1, 150);
      det_pulse(iv, "R8 R10 random traffic");
    end
    det_idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule